// File: doc/BRIEF.md
# Smart Panel Command Sequencer

The sequencer drives a small display panel that sits on an 8080-style parallel bus: an active-low chip select, a register/data select line (A0), separate active-low write and read strobes and an 8-bit data bus split into an output, an output enable and an input. Software or a fetch engine places 12-bit command words into an internal queue. The sequencer takes one word at a time. It can write a command byte or a data byte, stream pixel bytes from a valid/ready input, read the panel status or frame memory, wait for a rising vertical sync edge, skip the word, or raise a command interrupt.

Every bus access has three phases: setup, strobe and hold. The lengths come from programmable cycle counts. Read and write share one setup/hold length and one strobe length, and each is the larger of its read and write settings. A programmable inhibit gap separates a write from the next access, and a programmable output-hold gap follows each read. A read stores its byte in a result word and raises a read flag. After a status read, the sequencer waits until software grants continuation. Both interrupt flags clear when a one is written to them.

Top module: `spnl_seq`

## Requirements
- R1: A command word holds the payload in bits 7:0, the A0 level in bit 8 and the opcode in bits 11:9. Opcode 1 makes one write access that drives A0 from bit 8 and the payload on `lcd_d_out`, with `lcd_d_oe` high. The data bus holds steady for the whole access.
- R2: Each access holds `lcd_cs_n` low for 2·S+P cycles with A0 stable throughout. The strobe (`lcd_wr_n` or `lcd_rd_n`) is low for the middle P cycles. S is the larger of the two setup settings and P is the larger of the two pulse settings, and a setting of 0 counts as 1.
- R3: When two queued accesses follow a write, `lcd_cs_n` stays high for exactly inhibit+2 cycles between them.
- R4: Opcode 0 makes a read access that pulses `lcd_rd_n` with `lcd_d_oe` low. The byte on `lcd_d_in` in the last strobe cycle is stored. `rd_result` then holds that byte in bits 7:0, the A0 level in bit 8, status-OK=1 in bit 9 and continue=0 in bit 10. The next queued access starts exactly out_hold+2 cycles after `lcd_cs_n` rises.
- R5: After a read with A0=0 (status read), no further command runs until `cont_set` is pulsed. The pulse sets bit 10 of `rd_result` and clears bit 9.
- R6: Opcode 2 raises `pix_ready` and writes each accepted pixel byte with A0=1. It stops after the byte marked `pix_last`. Consecutive bytes are inhibit+1 cycles apart when pixels are ready, and `pix_ready` is never high during an access.
- R7: Opcode 3 holds the sequencer until a rising edge on `vsync`. No access occurs while it waits.
- R8: Opcode 5 sets `irq_cmd`. Opcodes 4, 6 and 7 cause no bus activity and set no flag.
- R9: Each completed read sets `irq_rd`.
- R10: A pulse on `irq_clr_rd` or `irq_clr_cmd` clears only its own flag. If a set and a clear for the same flag arrive in the same cycle, the set wins.
- R11: `cmd_full` rises once the queue holds FIFO_DEPTH words. A push while full is dropped.
- R12: After reset, `lcd_cs_n`, `lcd_wr_n` and `lcd_rd_n` are high. `lcd_d_oe`, both flags, `rd_result`, `pix_ready` and `cmd_full` are low, and `seq_idle` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_push | input | 1 | Write one command word into the queue |
| cmd_word | input | DW+4 | Command word (opcode, A0, payload) |
| cmd_full | output | 1 | Queue full |
| pix_valid | input | 1 | Pixel byte offered |
| pix_data | input | DW | Pixel byte |
| pix_last | input | 1 | Marks the final byte of a frame |
| pix_ready | output | 1 | Pixel byte accepted this cycle when valid |
| vsync | input | 1 | Vertical sync from the panel |
| cfg_setup_rd | input | TW | Read setup/hold length in cycles |
| cfg_setup_wr | input | TW | Write setup/hold length in cycles |
| cfg_pulse_rd | input | TW | Read strobe length in cycles |
| cfg_pulse_wr | input | TW | Write strobe length in cycles |
| cfg_inhibit | input | TW | Gap after a write |
| cfg_out_hold | input | TW | Gap after a read |
| cont_set | input | 1 | Grant continuation after a status read |
| irq_clr_rd | input | 1 | Clear the read flag |
| irq_clr_cmd | input | 1 | Clear the command-interrupt flag |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_a0 | output | 1 | Register/data select |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_d_out | output | DW | Data driven to the panel |
| lcd_d_oe | output | 1 | Data output enable |
| lcd_d_in | input | DW | Data returned by the panel |
| rd_result | output | DW+3 | Read result: byte, A0, status OK, continue |
| irq_rd | output | 1 | Read-completed flag |
| irq_cmd | output | 1 | Command-interrupt flag |
| seq_idle | output | 1 | Sequencer idle with an empty queue |

## Verification
Two events can land in the same cycle: a flag being set, either by a finished read or by an interrupt opcode, and software writing one to clear that same flag. The bench provokes this by holding the clear input high for the whole command. The set must win, so the flag must be seen high for exactly one cycle before the continuing clear removes it. A second overlap is a continuation grant arriving around a read capture. The bench judges it through the continue and status-OK bits after the stall.

// File: rtl/spnl_pkg.sv
package spnl_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_PIX, ST_SETUP, ST_STROBE, ST_HOLD,
    ST_OHOLD, ST_GAP, ST_WAIT_VS, ST_WAIT_CONT
  } seq_st_t;

  localparam logic [2:0] OP_READ  = 3'd0;
  localparam logic [2:0] OP_WRITE = 3'd1;
  localparam logic [2:0] OP_FRAME = 3'd2;
  localparam logic [2:0] OP_VSYNC = 3'd3;
  localparam logic [2:0] OP_IRQ   = 3'd5;
endpackage

// File: rtl/spnl_fifo.sv
module spnl_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_wr, do_rd;

  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
    if (do_rd) dout <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spnl_timer.sv
module spnl_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expire
);
  logic [TW-1:0] cnt;

  assign expire = (cnt == TW'(1));

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= TW'(1);
    else if (load)
      cnt <= (len == '0) ? TW'(1) : len;
    else if (cnt > TW'(1))
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/spnl_rise.sv
module spnl_rise (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic q;

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= din;
  end

  assign rise = din && !q;
endmodule

// File: rtl/spnl_seq.sv
module spnl_seq
  import spnl_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TW         = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int CMD_W     = DW + 4,
  localparam int RES_W     = DW + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_push,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             cmd_full,
  input  logic             pix_valid,
  input  logic [DW-1:0]    pix_data,
  input  logic             pix_last,
  output logic             pix_ready,
  input  logic             vsync,
  input  logic [TW-1:0]    cfg_setup_rd,
  input  logic [TW-1:0]    cfg_setup_wr,
  input  logic [TW-1:0]    cfg_pulse_rd,
  input  logic [TW-1:0]    cfg_pulse_wr,
  input  logic [TW-1:0]    cfg_inhibit,
  input  logic [TW-1:0]    cfg_out_hold,
  input  logic             cont_set,
  input  logic             irq_clr_rd,
  input  logic             irq_clr_cmd,
  output logic             lcd_cs_n,
  output logic             lcd_a0,
  output logic             lcd_wr_n,
  output logic             lcd_rd_n,
  output logic [DW-1:0]    lcd_d_out,
  output logic             lcd_d_oe,
  input  logic [DW-1:0]    lcd_d_in,
  output logic [RES_W-1:0] rd_result,
  output logic             irq_rd,
  output logic             irq_cmd,
  output logic             seq_idle
);
  localparam int A0_BIT = DW;
  localparam int OP_LSB = DW + 1;

  seq_st_t st, st_n;

  logic [CMD_W-1:0] fifo_dout;
  logic             fifo_empty, fifo_pop;
  logic             tmr_load, tmr_expire;
  logic [TW-1:0]    tmr_len;
  logic             vs_rise;

  logic [TW-1:0] dur_setup, dur_pulse;
  logic [2:0]    cur_op;

  logic          rd_q, a0_q, last_q, stream_q;
  logic [DW-1:0] dat_q;
  logic          rd_nx, a0_nx, last_nx, stream_nx;
  logic [DW-1:0] dat_nx;

  logic          capture, set_irq_rd, set_irq_cmd;
  logic [DW-1:0] res_data;
  logic          res_a0, res_ok, res_cont;
  logic          acc_nx;

  // Command queue
  spnl_fifo #(.W(CMD_W), .DEPTH(FIFO_DEPTH)) cmd_q_i (
    .clk   (clk),
    .rst   (rst),
    .push  (cmd_push),
    .din   (cmd_word),
    .pop   (fifo_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (cmd_full)
  );

  // Shared phase timer
  spnl_timer #(.TW(TW)) phase_tmr_i (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .len    (tmr_len),
    .expire (tmr_expire)
  );

  spnl_rise vs_edge_i (
    .clk  (clk),
    .rst  (rst),
    .din  (vsync),
    .rise (vs_rise)
  );

  // Read and write share one setting each; the larger wins
  assign dur_setup = (cfg_setup_rd > cfg_setup_wr) ? cfg_setup_rd : cfg_setup_wr;
  assign dur_pulse = (cfg_pulse_rd > cfg_pulse_wr) ? cfg_pulse_rd : cfg_pulse_wr;
  assign cur_op    = fifo_dout[OP_LSB +: 3];

  always_comb begin
    st_n        = st;
    tmr_load    = 1'b0;
    tmr_len     = '0;
    fifo_pop    = 1'b0;
    rd_nx       = rd_q;
    a0_nx       = a0_q;
    dat_nx      = dat_q;
    last_nx     = last_q;
    stream_nx   = stream_q;
    capture     = 1'b0;
    set_irq_rd  = 1'b0;
    set_irq_cmd = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (!fifo_empty) begin
          fifo_pop = 1'b1;
          st_n     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        case (cur_op)
          OP_READ: begin
            rd_nx    = 1'b1;
            a0_nx    = fifo_dout[A0_BIT];
            dat_nx   = '0;
            st_n     = ST_SETUP;
            tmr_load = 1'b1;
            tmr_len  = dur_setup;
          end
          OP_WRITE: begin
            rd_nx    = 1'b0;
            a0_nx    = fifo_dout[A0_BIT];
            dat_nx   = fifo_dout[DW-1:0];
            st_n     = ST_SETUP;
            tmr_load = 1'b1;
            tmr_len  = dur_setup;
          end
          OP_FRAME: begin
            stream_nx = 1'b1;
            st_n      = ST_PIX;
          end
          OP_VSYNC: st_n = ST_WAIT_VS;
          OP_IRQ: begin
            set_irq_cmd = 1'b1;
            st_n        = ST_IDLE;
          end
          default: st_n = ST_IDLE;
        endcase
      end
      ST_PIX: begin
        if (pix_valid) begin
          rd_nx    = 1'b0;
          a0_nx    = 1'b1;
          dat_nx   = pix_data;
          last_nx  = pix_last;
          st_n     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_len  = dur_setup;
        end
      end
      ST_SETUP: begin
        if (tmr_expire) begin
          st_n     = ST_STROBE;
          tmr_load = 1'b1;
          tmr_len  = dur_pulse;
        end
      end
      ST_STROBE: begin
        if (tmr_expire) begin
          capture  = rd_q;
          st_n     = ST_HOLD;
          tmr_load = 1'b1;
          tmr_len  = dur_setup;
        end
      end
      ST_HOLD: begin
        if (tmr_expire) begin
          tmr_load = 1'b1;
          if (rd_q) begin
            st_n    = ST_OHOLD;
            tmr_len = cfg_out_hold;
          end else begin
            st_n    = ST_GAP;
            tmr_len = cfg_inhibit;
          end
        end
      end
      ST_OHOLD: begin
        if (tmr_expire) begin
          set_irq_rd = 1'b1;
          st_n       = a0_q ? ST_IDLE : ST_WAIT_CONT;
        end
      end
      ST_GAP: begin
        if (tmr_expire) begin
          if (stream_q && !last_q) begin
            st_n = ST_PIX;
          end else begin
            stream_nx = 1'b0;
            st_n      = ST_IDLE;
          end
        end
      end
      ST_WAIT_VS: begin
        if (vs_rise) st_n = ST_IDLE;
      end
      ST_WAIT_CONT: begin
        if (res_cont) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign acc_nx = (st_n == ST_SETUP) || (st_n == ST_STROBE) || (st_n == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      rd_q      <= 1'b0;
      a0_q      <= 1'b0;
      dat_q     <= '0;
      last_q    <= 1'b0;
      stream_q  <= 1'b0;
      lcd_cs_n  <= 1'b1;
      lcd_wr_n  <= 1'b1;
      lcd_rd_n  <= 1'b1;
      lcd_d_oe  <= 1'b0;
      pix_ready <= 1'b0;
    end else begin
      st        <= st_n;
      rd_q      <= rd_nx;
      a0_q      <= a0_nx;
      dat_q     <= dat_nx;
      last_q    <= last_nx;
      stream_q  <= stream_nx;
      lcd_cs_n  <= !acc_nx;
      lcd_wr_n  <= !((st_n == ST_STROBE) && !rd_nx);
      lcd_rd_n  <= !((st_n == ST_STROBE) && rd_nx);
      lcd_d_oe  <= acc_nx && !rd_nx;
      pix_ready <= (st_n == ST_PIX);
    end
  end

  assign lcd_a0    = a0_q;
  assign lcd_d_out = dat_q;

  // Read result and interrupt flags
  always_ff @(posedge clk) begin
    if (rst) begin
      res_data <= '0;
      res_a0   <= 1'b0;
      res_ok   <= 1'b0;
      res_cont <= 1'b0;
      irq_rd   <= 1'b0;
      irq_cmd  <= 1'b0;
    end else begin
      if (cont_set) begin
        res_cont <= 1'b1;
        res_ok   <= 1'b0;
      end
      if (capture) begin
        res_data <= lcd_d_in;
        res_a0   <= a0_q;
        res_ok   <= 1'b1;
        res_cont <= 1'b0;
      end
      if (set_irq_rd)      irq_rd <= 1'b1;
      else if (irq_clr_rd) irq_rd <= 1'b0;
      if (set_irq_cmd)      irq_cmd <= 1'b1;
      else if (irq_clr_cmd) irq_cmd <= 1'b0;
    end
  end

  assign rd_result = {res_cont, res_ok, res_a0, res_data};
  assign seq_idle  = (st == ST_IDLE) && fifo_empty;
endmodule

// File: rtl/spnl_seq_chk.sv
module spnl_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          lcd_cs_n,
  input logic          lcd_a0,
  input logic          lcd_wr_n,
  input logic          lcd_rd_n,
  input logic [DW-1:0] lcd_d_out,
  input logic          lcd_d_oe,
  input logic          pix_ready
);
  AST_STROBE_UNDER_CS: assert property (@(posedge clk) disable iff (rst)
    (!lcd_wr_n || !lcd_rd_n) |-> !lcd_cs_n); // R2

  AST_A0_HELD: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && !$past(lcd_cs_n)) |-> $stable(lcd_a0)); // R2

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (!lcd_cs_n && !$past(lcd_cs_n) && lcd_d_oe) |-> $stable(lcd_d_out)); // R1

  AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    !lcd_rd_n |-> !lcd_d_oe); // R4

  AST_PIX_OFF_BUS: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> lcd_cs_n); // R6

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !lcd_rd_n |-> lcd_wr_n); // R2
endmodule

bind spnl_seq spnl_seq_chk #(.DW(DW)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .lcd_cs_n  (lcd_cs_n),
  .lcd_a0    (lcd_a0),
  .lcd_wr_n  (lcd_wr_n),
  .lcd_rd_n  (lcd_rd_n),
  .lcd_d_out (lcd_d_out),
  .lcd_d_oe  (lcd_d_oe),
  .pix_ready (pix_ready)
);

// File: tb/spnl_seq_tb_top.sv
`timescale 1ns/1ps
module spnl_seq_tb_top;
  localparam int DW = 8;
  localparam int TW = 4;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          cmd_push = 1'b0;
  logic [11:0]   cmd_word = '0;
  logic          cmd_full;
  logic          pix_valid = 1'b0;
  logic [DW-1:0] pix_data = '0;
  logic          pix_last = 1'b0;
  logic          pix_ready;
  logic          vsync = 1'b0;
  logic [TW-1:0] cfg_setup_rd = 4'd1, cfg_setup_wr = 4'd1;
  logic [TW-1:0] cfg_pulse_rd = 4'd1, cfg_pulse_wr = 4'd1;
  logic [TW-1:0] cfg_inhibit = 4'd1, cfg_out_hold = 4'd1;
  logic          cont_set = 1'b0, irq_clr_rd = 1'b0, irq_clr_cmd = 1'b0;
  logic          lcd_cs_n, lcd_a0, lcd_wr_n, lcd_rd_n, lcd_d_oe;
  logic [DW-1:0] lcd_d_out;
  logic [DW-1:0] lcd_d_in = '0;
  logic [10:0]   rd_result;
  logic          irq_rd, irq_cmd, seq_idle;

  spnl_seq #(.DW(DW), .TW(TW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .cmd_push(cmd_push), .cmd_word(cmd_word), .cmd_full(cmd_full),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_last(pix_last), .pix_ready(pix_ready),
    .vsync(vsync), .cfg_setup_rd(cfg_setup_rd), .cfg_setup_wr(cfg_setup_wr),
    .cfg_pulse_rd(cfg_pulse_rd), .cfg_pulse_wr(cfg_pulse_wr), .cfg_inhibit(cfg_inhibit),
    .cfg_out_hold(cfg_out_hold), .cont_set(cont_set), .irq_clr_rd(irq_clr_rd),
    .irq_clr_cmd(irq_clr_cmd), .lcd_cs_n(lcd_cs_n), .lcd_a0(lcd_a0), .lcd_wr_n(lcd_wr_n),
    .lcd_rd_n(lcd_rd_n), .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in),
    .rd_result(rd_result), .irq_rd(irq_rd), .irq_cmd(irq_cmd), .seq_idle(seq_idle)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Bus monitor: records each chip-select window
  int n_acc = 0, gap_cnt = 0, cs_len = 0, st_len = 0;
  bit in_acc = 0, acc_isrd = 0, a0_bad = 0, oe_bad = 0;
  int a_cs[64], a_st[64], a_gap[64], a_a0[64], a_dat[64], a_rd[64];

  always @(negedge clk) begin
    if (!rst) begin
      int idx;
      idx = (n_acc < 64) ? n_acc : 63;
      if (!lcd_cs_n) begin
        if (!in_acc) begin
          in_acc = 1; cs_len = 0; st_len = 0; acc_isrd = 0;
          a_gap[idx] = gap_cnt; a_a0[idx] = int'(lcd_a0); a_dat[idx] = 0;
        end
        cs_len++;
        if (!lcd_wr_n) begin st_len++; a_dat[idx] = int'(lcd_d_out); end
        if (!lcd_rd_n) begin st_len++; acc_isrd = 1; end
        if (!lcd_rd_n && lcd_d_oe) oe_bad = 1;
        if (int'(lcd_a0) != a_a0[idx]) a0_bad = 1;
      end else begin
        if (in_acc) begin
          in_acc = 0;
          a_cs[idx] = cs_len; a_st[idx] = st_len; a_rd[idx] = int'(acc_isrd);
          n_acc++;
          gap_cnt = 0;
        end
        gap_cnt++;
      end
    end
  end

  function automatic logic [11:0] mk(input int op, input int a0, input int pay);
    return {op[2:0], a0[0], pay[7:0]};
  endfunction

  task automatic push(input logic [11:0] w);
    @(posedge clk); #1; cmd_push = 1'b1; cmd_word = w;
    @(posedge clk); #1; cmd_push = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!seq_idle);
    repeat (2) @(negedge clk);
  endtask

  task automatic reset_mon();
    n_acc = 0; a0_bad = 0; oe_bad = 0;
  endtask

  task automatic set_cfg(input int sr, input int sw, input int pr, input int pw, input int ih, input int oh);
    cfg_setup_rd = sr[3:0]; cfg_setup_wr = sw[3:0];
    cfg_pulse_rd = pr[3:0]; cfg_pulse_wr = pw[3:0];
    cfg_inhibit = ih[3:0]; cfg_out_hold = oh[3:0];
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(lcd_cs_n && lcd_wr_n && lcd_rd_n && !lcd_d_oe, "R12 bus idle", int'({lcd_cs_n, lcd_wr_n, lcd_rd_n, lcd_d_oe}), 14);
    chk(!irq_rd && !irq_cmd && rd_result == 0, "R12 flags/result", int'(rd_result), 0);
    chk(seq_idle && !pix_ready && !cmd_full, "R12 idle", int'({seq_idle, pix_ready, cmd_full}), 4);

    // Sweep over timing settings: R1 R2 R3 R4 R9 R10
    for (int sr = 0; sr < 3; sr++)
      for (int sw = 0; sw < 3; sw++)
        for (int pr = 1; pr < 4; pr++)
          for (int pw = 1; pw < 4; pw++)
            for (int ih = 1; ih < 4; ih++)
              for (int oh = 1; oh < 3; oh++) begin
                int s, p, din, wd;
                s = (sr > sw) ? sr : sw; if (s < 1) s = 1;
                p = (pr > pw) ? pr : pw;
                din = (sr * 61 + sw * 29 + pr * 17 + pw * 11 + ih * 7 + oh * 3) & 255;
                wd = din ^ 8'hC3;
                set_cfg(sr, sw, pr, pw, ih, oh);
                lcd_d_in = din[7:0];
                reset_mon();
                push(mk(1, 0, 8'h2A));
                push(mk(1, 1, wd));
                push(mk(0, 1, 0));
                push(mk(1, 0, 8'h5A));
                wait_idle();
                chk(n_acc == 4, "R1 access count", n_acc, 4);
                for (int k = 0; k < 4; k++) begin
                  chk(a_cs[k] == 2 * s + p, "R2 cs low length", a_cs[k], 2 * s + p);
                  chk(a_st[k] == p, "R2 strobe length", a_st[k], p);
                  chk(a_rd[k] == ((k == 2) ? 1 : 0), "R4 strobe kind", a_rd[k], (k == 2) ? 1 : 0);
                end
                chk(a_a0[0] == 0 && a_a0[1] == 1 && a_a0[2] == 1, "R1 A0 levels", a_a0[0] + 2 * a_a0[1] + 4 * a_a0[2], 6);
                chk(a_dat[0] == 8'h2A, "R1 command byte", a_dat[0], 8'h2A);
                chk(a_dat[1] == wd, "R1 data byte", a_dat[1], wd);
                chk(a_gap[1] == ih + 2, "R3 gap after write", a_gap[1], ih + 2);
                chk(a_gap[2] == ih + 2, "R3 gap before read", a_gap[2], ih + 2);
                chk(a_gap[3] == oh + 2, "R4 gap after read", a_gap[3], oh + 2);
                chk(rd_result == {1'b0, 1'b1, 1'b1, din[7:0]}, "R4 read result", int'(rd_result), 768 + din);
                chk(!a0_bad && !oe_bad, "R2 A0 stable / R4 no drive", int'({a0_bad, oe_bad}), 0);
                chk(irq_rd == 1'b1, "R9 read flag set", int'(irq_rd), 1);
                @(posedge clk); #1 irq_clr_rd = 1'b1;
                @(posedge clk); #1 irq_clr_rd = 1'b0;
                @(negedge clk);
                chk(irq_rd == 1'b0, "R10 read flag cleared", int'(irq_rd), 0);
              end

    // R5 status read stalls until continue; R11 queue full
    set_cfg(1, 1, 1, 1, 1, 1);
    lcd_d_in = 8'hA5;
    reset_mon();
    push(mk(0, 0, 0));
    repeat (30) @(negedge clk);
    chk(n_acc == 1 && !seq_idle, "R5 stalled after status read", n_acc, 1);
    chk(rd_result == {1'b0, 1'b1, 1'b0, 8'hA5}, "R5 status result", int'(rd_result), 512 + 8'hA5);
    for (int k = 0; k < DEPTH; k++) push(mk(1, 1, 8'h91 + k));
    @(negedge clk);
    chk(cmd_full == 1'b1, "R11 full after depth pushes", int'(cmd_full), 1);
    push(mk(1, 1, 8'h99));
    repeat (20) @(negedge clk);
    chk(n_acc == 1, "R5 no command before continue", n_acc, 1);
    @(posedge clk); #1 cont_set = 1'b1;
    @(posedge clk); #1 cont_set = 1'b0;
    wait_idle();
    chk(rd_result[10:9] == 2'b10, "R5 continue set, ok cleared", int'(rd_result[10:9]), 2);
    chk(n_acc == 1 + DEPTH, "R11 extra push dropped", n_acc, 1 + DEPTH);
    chk(a_dat[DEPTH] == 8'h91 + DEPTH - 1, "R11 last queued byte", a_dat[DEPTH], 8'h91 + DEPTH - 1);

    // R6 pixel stream
    set_cfg(1, 1, 2, 1, 2, 1);
    reset_mon();
    push(mk(2, 1, 0));
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      pix_valid = 1'b1; pix_data = 8'hB0 + k[7:0]; pix_last = (k == 2);
      do @(negedge clk); while (!pix_ready);
    end
    @(posedge clk); #1 pix_valid = 1'b0; pix_last = 1'b0;
    wait_idle();
    chk(n_acc == 3, "R6 byte count", n_acc, 3);
    for (int k = 0; k < 3; k++) begin
      chk(a_dat[k] == 8'hB0 + k && a_a0[k] == 1, "R6 pixel byte with A0=1", a_dat[k], 8'hB0 + k);
      chk(a_st[k] == 2 && a_rd[k] == 0, "R6 write strobe", a_st[k], 2);
    end
    chk(a_gap[1] == 3 && a_gap[2] == 3, "R6 inter-byte gap", a_gap[2], 3);
    chk(!pix_ready, "R6 ready dropped", int'(pix_ready), 0);

    // R7 wait for vsync
    reset_mon();
    push(mk(3, 0, 0));
    push(mk(1, 0, 8'h33));
    repeat (30) @(negedge clk);
    chk(n_acc == 0 && !seq_idle, "R7 held before vsync", n_acc, 0);
    @(posedge clk); #1 vsync = 1'b1;
    wait_idle();
    vsync = 1'b0;
    chk(n_acc == 1 && a_dat[0] == 8'h33, "R7 released by vsync", a_dat[0], 8'h33);

    // R8 no-op opcodes and interrupt opcode
    reset_mon();
    push(mk(4, 0, 8'h12));
    push(mk(6, 1, 8'h34));
    push(mk(7, 0, 8'h56));
    wait_idle();
    chk(n_acc == 0 && !irq_cmd, "R8 no-op opcodes silent", n_acc, 0);
    push(mk(5, 0, 0));
    wait_idle();
    chk(irq_cmd == 1'b1 && n_acc == 0, "R8 interrupt opcode", int'(irq_cmd), 1);

    // R10 clear only its own flag; set wins on collision
    lcd_d_in = 8'h0F;
    push(mk(0, 1, 0));
    wait_idle();
    @(posedge clk); #1 irq_clr_cmd = 1'b1;
    @(posedge clk); #1 irq_clr_cmd = 1'b0;
    @(negedge clk);
    chk(!irq_cmd && irq_rd, "R10 clear cmd leaves read flag", int'({irq_cmd, irq_rd}), 1);
    begin
      int hi;
      hi = 0;
      @(posedge clk); #1 irq_clr_cmd = 1'b1;
      push(mk(5, 0, 0));
      repeat (30) begin @(negedge clk); if (irq_cmd) hi++; end
      irq_clr_cmd = 1'b0;
      chk(hi == 1, "R10 cmd set beats clear", hi, 1);
      hi = 0;
      @(posedge clk); #1 irq_clr_rd = 1'b1;
      push(mk(0, 1, 0));
      repeat (40) begin @(negedge clk); if (irq_rd) hi++; end
      irq_clr_rd = 1'b0;
      chk(hi == 1, "R9 R10 read set beats clear", hi, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule